// File: doc/BRIEF.md
# Speculation-Aware Predicate and Poison Register File

This block is the architectural register state of a predicated wide-issue core. It holds a bank of general registers, each carrying a poison flag, and a bank of one-bit predicates. A speculative load can run ahead of the branch that guards it. If the load faults, the exception is not raised. The fault is instead recorded as poison on the destination register. A later check operation on that register raises the deferred exception only if the poison is present.

The predicate bank is written by compare operations. Each compare produces a result and its complement and writes them into two named predicates in one step. The upper part of the bank rotates under a pulse at every iteration of a software-pipelined loop. A stage-valid bit enters at the bottom of the rotating part on each pulse. Each pipeline stage's predicate therefore marks whether that stage is filling (prologue), running in full (kernel) or draining (epilogue). The bottom predicates do not rotate. Predicate 0 is hard-wired true, so unguarded operations can name it.

Top module: `pp_regfile`

## Requirements
- R1: After reset, every general register reads 0 with poison clear, and every predicate reads 0 except predicate 0, which reads 1.
- R2: A normal write (wr_en=1, wr_spec=0) stores wr_data and clears the poison flag of that register. Both are visible on the read ports from the next cycle.
- R3: A read port whose index equals the index of the write in the same cycle returns the value and poison that this write leaves behind (write-before-read forwarding).
- R4: A speculative load that reports a fault (wr_spec=1, wr_fault=1) sets the register's poison flag and leaves its data unchanged.
- R5: A speculative load without a fault (wr_spec=1, wr_fault=0) stores its data and clears the poison flag.
- R6: chk_trap is 1 exactly when chk_en=1 and the register chk_idx is poisoned. This includes poison being set or cleared by a write in the same cycle.
- R7: A compare writes its result to predicate cmp_pt and the complement to cmp_pf, visible from the next cycle. cmp_kind encodes the test: 0 equal, 1 signed less-than, 2 unsigned less-than, 3 not equal.
- R8: Predicate 0 always reads 1. Compare writes that target predicate 0 are ignored.
- R9: On rot_en, predicate k moves to k+1 for 16 ≤ k ≤ 62, predicate 63 is dropped, and predicate 16 takes rot_in. Predicates 0 to 15 are unchanged.
- R10: When a compare and a rotation occur in the same cycle, the compare's two targets take the compare values. All other predicates follow the rotation.
- R11: If cmp_pt equals cmp_pf, that predicate takes the compare result, not its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 7 | Write register index |
| wr_data | input | 64 | Write data |
| wr_spec | input | 1 | Write comes from a speculative load |
| wr_fault | input | 1 | Speculative load reported a fault |
| rd_a_idx | input | 7 | Read port A index |
| rd_a_data | output | 64 | Read port A data |
| rd_a_poison | output | 1 | Read port A poison flag |
| rd_b_idx | input | 7 | Read port B index |
| rd_b_data | output | 64 | Read port B data |
| rd_b_poison | output | 1 | Read port B poison flag |
| chk_en | input | 1 | Check operation valid |
| chk_idx | input | 7 | Register being checked |
| chk_trap | output | 1 | Deferred exception raised |
| cmp_en | input | 1 | Compare valid |
| cmp_kind | input | 2 | Compare test selector |
| cmp_a | input | 64 | Compare operand A |
| cmp_b | input | 64 | Compare operand B |
| cmp_pt | input | 6 | Predicate receiving the result |
| cmp_pf | input | 6 | Predicate receiving the complement |
| rot_en | input | 1 | Rotate the upper predicate bank |
| rot_in | input | 1 | Stage-valid bit inserted on rotation |
| pr_rd_idx | input | 6 | Predicate read index |
| pr_rd_val | output | 1 | Predicate read value |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is a compare and a rotation pulse. They collide because the compare targets are renamed by the rotation in the same edge. The bench issues both together, with targets inside the rotating range. It compares the whole predicate bank against a model that rotates first and then applies the compare. The second pair is a speculative-load fault and a check on the same register. The bench asserts both on one cycle and expects the trap at once through the forwarding path.

// File: rtl/pp_regfile_pkg.sv
`timescale 1ns/1ps
package pp_regfile_pkg;
   typedef enum logic [1:0] {
      CMP_EQ  = 2'd0,
      CMP_LT  = 2'd1,
      CMP_LTU = 2'd2,
      CMP_NE  = 2'd3
   } cmp_kind_e;
endpackage

// File: rtl/pp_gpr_bank.sv
`timescale 1ns/1ps
module pp_gpr_bank #(
   parameter int N      = 128,
   parameter int W      = 64,
   parameter int NRD    = 2,
   parameter bit BYPASS = 1'b1,
   parameter int IW     = $clog2(N)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IW-1:0]         wr_idx,
   input  logic [W-1:0]          wr_data,
   input  logic                  wr_spec,
   input  logic                  wr_fault,
   input  logic [NRD-1:0][IW-1:0] rd_idx,
   output logic [NRD-1:0][W-1:0]  rd_data,
   output logic [NRD-1:0]         rd_pois,
   input  logic [IW-1:0]         chk_idx,
   output logic                  chk_pois
);
   logic [W-1:0] mem [N];
   logic [N-1:0] pois;
   logic         upd_data;
   logic         new_pois;

   assign new_pois = wr_spec & wr_fault;
   assign upd_data = wr_en & ~new_pois;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) mem[i] <= '0;
         pois <= '0;
      end else if (wr_en) begin
         if (upd_data) mem[wr_idx] <= wr_data;
         pois[wr_idx] <= new_pois;
      end
   end

   generate
      if (BYPASS) begin : g_fwd
         for (genvar g = 0; g < NRD; g++) begin : g_rd
            logic hit;
            assign hit        = wr_en && (wr_idx == rd_idx[g]);
            assign rd_data[g] = (hit && upd_data) ? wr_data : mem[rd_idx[g]];
            assign rd_pois[g] = hit ? new_pois : pois[rd_idx[g]];
         end
         assign chk_pois = (wr_en && (wr_idx == chk_idx)) ? new_pois : pois[chk_idx];
      end else begin : g_nofwd
         for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rd_data[g] = mem[rd_idx[g]];
            assign rd_pois[g] = pois[rd_idx[g]];
         end
         assign chk_pois = pois[chk_idx];
      end
   endgenerate
endmodule

// File: rtl/pp_pred_cmp.sv
`timescale 1ns/1ps
module pp_pred_cmp
   import pp_regfile_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  cmp_kind_e    kind,
   output logic         res
);
   always_comb begin
      case (kind)
         CMP_EQ:  res = (a == b);
         CMP_LT:  res = ($signed(a) < $signed(b));
         CMP_LTU: res = (a < b);
         default: res = (a != b);
      endcase
   end
endmodule

// File: rtl/pp_pred_bank.sv
`timescale 1ns/1ps
module pp_pred_bank #(
   parameter int NP       = 64,
   parameter int ROT_BASE = 16,
   parameter int PW       = $clog2(NP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rot_en,
   input  logic          rot_in,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_t_idx,
   input  logic [PW-1:0] wr_f_idx,
   input  logic          wr_res,
   input  logic [PW-1:0] rd_idx,
   output logic          rd_val,
   output logic [NP-1:0] bank
);
   localparam logic [NP-1:0] RST_VAL = {{(NP-1){1'b0}}, 1'b1};

   logic [NP-1:0] rotated;
   logic [NP-1:0] nxt;

   generate
      if (ROT_BASE < NP) begin : g_rot
         always_comb begin
            rotated = bank;
            if (rot_en) begin
               rotated[ROT_BASE] = rot_in;
               for (int k = ROT_BASE + 1; k < NP; k++) rotated[k] = bank[k-1];
            end
         end
      end else begin : g_static
         logic unused_rot;
         assign unused_rot = rot_en ^ rot_in;
         assign rotated    = bank;
      end
   endgenerate

   always_comb begin
      nxt = rotated;
      if (wr_en) begin
         nxt[wr_f_idx] = ~wr_res;
         nxt[wr_t_idx] = wr_res;
      end
      nxt[0] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bank <= RST_VAL;
      else        bank <= nxt;
   end

   assign rd_val = (rd_idx == '0) ? 1'b1 : bank[rd_idx];
endmodule

// File: rtl/pp_regfile.sv
`timescale 1ns/1ps
module pp_regfile
   import pp_regfile_pkg::*;
#(
   parameter int GR_COUNT = 128,
   parameter int GR_WIDTH = 64,
   parameter int PR_COUNT = 64,
   parameter int PR_ROT   = 16,
   parameter bit FORWARD  = 1'b1,
   parameter int GR_IW    = $clog2(GR_COUNT),
   parameter int PR_IW    = $clog2(PR_COUNT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [GR_IW-1:0]    wr_idx,
   input  logic [GR_WIDTH-1:0] wr_data,
   input  logic                wr_spec,
   input  logic                wr_fault,
   input  logic [GR_IW-1:0]    rd_a_idx,
   output logic [GR_WIDTH-1:0] rd_a_data,
   output logic                rd_a_poison,
   input  logic [GR_IW-1:0]    rd_b_idx,
   output logic [GR_WIDTH-1:0] rd_b_data,
   output logic                rd_b_poison,
   input  logic                chk_en,
   input  logic [GR_IW-1:0]    chk_idx,
   output logic                chk_trap,
   input  logic                cmp_en,
   input  logic [1:0]          cmp_kind,
   input  logic [GR_WIDTH-1:0] cmp_a,
   input  logic [GR_WIDTH-1:0] cmp_b,
   input  logic [PR_IW-1:0]    cmp_pt,
   input  logic [PR_IW-1:0]    cmp_pf,
   input  logic                rot_en,
   input  logic                rot_in,
   input  logic [PR_IW-1:0]    pr_rd_idx,
   output logic                pr_rd_val
);
   localparam int NRD = 2;

   generate
      if (GR_COUNT != (1 << GR_IW)) begin : g_bad_gr
         $error("GR_COUNT must be a power of two matching GR_IW");
      end
      if (PR_COUNT != (1 << PR_IW)) begin : g_bad_pr
         $error("PR_COUNT must be a power of two matching PR_IW");
      end
      if (PR_ROT < 1 || PR_ROT > PR_COUNT) begin : g_bad_rot
         $error("PR_ROT must lie in 1..PR_COUNT");
      end
   endgenerate

   logic [NRD-1:0][GR_IW-1:0]    rd_idx_v;
   logic [NRD-1:0][GR_WIDTH-1:0] rd_data_v;
   logic [NRD-1:0]               rd_pois_v;
   logic                         chk_pois;
   logic                         cmp_res;
   logic [PR_COUNT-1:0]          pr_vec;

   assign rd_idx_v[0] = rd_a_idx;
   assign rd_idx_v[1] = rd_b_idx;
   assign rd_a_data   = rd_data_v[0];
   assign rd_b_data   = rd_data_v[1];
   assign rd_a_poison = rd_pois_v[0];
   assign rd_b_poison = rd_pois_v[1];
   assign chk_trap    = chk_en & chk_pois;

   pp_gpr_bank #(
      .N(GR_COUNT), .W(GR_WIDTH), .NRD(NRD), .BYPASS(FORWARD), .IW(GR_IW)
   ) u_gpr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .wr_spec  (wr_spec),
      .wr_fault (wr_fault),
      .rd_idx   (rd_idx_v),
      .rd_data  (rd_data_v),
      .rd_pois  (rd_pois_v),
      .chk_idx  (chk_idx),
      .chk_pois (chk_pois)
   );

   pp_pred_cmp #(.W(GR_WIDTH)) u_cmp (
      .a    (cmp_a),
      .b    (cmp_b),
      .kind (cmp_kind_e'(cmp_kind)),
      .res  (cmp_res)
   );

   pp_pred_bank #(.NP(PR_COUNT), .ROT_BASE(PR_ROT), .PW(PR_IW)) u_pred (
      .clk      (clk),
      .rst_n    (rst_n),
      .rot_en   (rot_en),
      .rot_in   (rot_in),
      .wr_en    (cmp_en),
      .wr_t_idx (cmp_pt),
      .wr_f_idx (cmp_pf),
      .wr_res   (cmp_res),
      .rd_idx   (pr_rd_idx),
      .rd_val   (pr_rd_val),
      .bank     (pr_vec)
   );
endmodule

// File: rtl/pp_regfile_checker.sv
`timescale 1ns/1ps
module pp_regfile_checker #(
   parameter int GR_WIDTH = 64,
   parameter int PR_COUNT = 64,
   parameter int PR_ROT   = 16,
   parameter int GR_IW    = 7,
   parameter int PR_IW    = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [GR_IW-1:0]    wr_idx,
   input logic [GR_WIDTH-1:0] wr_data,
   input logic                wr_spec,
   input logic                wr_fault,
   input logic [GR_IW-1:0]    rd_a_idx,
   input logic [GR_WIDTH-1:0] rd_a_data,
   input logic                rd_a_poison,
   input logic                chk_en,
   input logic [GR_IW-1:0]    chk_idx,
   input logic                chk_trap,
   input logic                cmp_en,
   input logic [PR_IW-1:0]    cmp_pt,
   input logic [PR_IW-1:0]    cmp_pf,
   input logic                rot_en,
   input logic                rot_in,
   input logic [PR_IW-1:0]    pr_rd_idx,
   input logic                pr_rd_val,
   input logic [PR_COUNT-1:0] pr_vec
);
   logic                lw_v;
   logic [GR_IW-1:0]    lw_idx;
   logic [GR_WIDTH-1:0] lw_dat;
   logic                lf_v;
   logic [GR_IW-1:0]    lf_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lw_v   <= 1'b0;
         lf_v   <= 1'b0;
         lw_idx <= '0;
         lf_idx <= '0;
         lw_dat <= '0;
      end else begin
         lw_v   <= wr_en && !(wr_spec && wr_fault);
         lf_v   <= wr_en && wr_spec && wr_fault;
         lw_idx <= wr_idx;
         lf_idx <= wr_idx;
         lw_dat <= wr_data;
      end
   end

   // R2 and R5: a completed write is seen on port A with poison clear
   p_wr_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lw_v && rd_a_idx == lw_idx && !(wr_en && wr_idx == lw_idx))
      |-> (rd_a_data == lw_dat && !rd_a_poison));

   p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_spec && rd_a_idx == wr_idx) |-> (rd_a_data == wr_data && !rd_a_poison));

   p_fault_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lf_v && chk_en && chk_idx == lf_idx && !(wr_en && wr_idx == lf_idx)) |-> chk_trap);

   p_trap_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |-> !chk_trap);

   p_pred_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && cmp_pt != cmp_pf && cmp_pt != '0 && cmp_pf != '0)
      |=> (pr_vec[$past(cmp_pt)] != pr_vec[$past(cmp_pf)]));

   p_pred0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_rd_idx == '0) |-> (pr_rd_val && pr_vec[0]));

   p_rot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_en && !cmp_en)
      |=> (pr_vec[PR_ROT-1:0] == $past(pr_vec[PR_ROT-1:0])
           && pr_vec[PR_ROT] == $past(rot_in)
           && pr_vec[PR_COUNT-1:PR_ROT+1] == $past(pr_vec[PR_COUNT-2:PR_ROT])));
endmodule

bind pp_regfile pp_regfile_checker #(
   .GR_WIDTH(GR_WIDTH), .PR_COUNT(PR_COUNT), .PR_ROT(PR_ROT), .GR_IW(GR_IW), .PR_IW(PR_IW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
   .wr_spec(wr_spec), .wr_fault(wr_fault), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
   .rd_a_poison(rd_a_poison), .chk_en(chk_en), .chk_idx(chk_idx), .chk_trap(chk_trap),
   .cmp_en(cmp_en), .cmp_pt(cmp_pt), .cmp_pf(cmp_pf), .rot_en(rot_en), .rot_in(rot_in),
   .pr_rd_idx(pr_rd_idx), .pr_rd_val(pr_rd_val), .pr_vec(pr_vec)
);

// File: tb/tb_pp_regfile.sv
`timescale 1ns/1ps
module tb_pp_regfile;
   logic        clk, rst_n;
   logic        wr_en, wr_spec, wr_fault;
   logic [6:0]  wr_idx, rd_a_idx, rd_b_idx, chk_idx;
   logic [63:0] wr_data, rd_a_data, rd_b_data, cmp_a, cmp_b;
   logic        rd_a_poison, rd_b_poison, chk_en, chk_trap;
   logic        cmp_en, rot_en, rot_in, pr_rd_val;
   logic [1:0]  cmp_kind;
   logic [5:0]  cmp_pt, cmp_pf, pr_rd_idx;

   int n_run = 0;
   int n_fail = 0;
   logic [63:0] mdl;

   pp_regfile dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .wr_spec(wr_spec), .wr_fault(wr_fault), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_a_poison(rd_a_poison), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .rd_b_poison(rd_b_poison), .chk_en(chk_en), .chk_idx(chk_idx), .chk_trap(chk_trap),
      .cmp_en(cmp_en), .cmp_kind(cmp_kind), .cmp_a(cmp_a), .cmp_b(cmp_b),
      .cmp_pt(cmp_pt), .cmp_pf(cmp_pf), .rot_en(rot_en), .rot_in(rot_in),
      .pr_rd_idx(pr_rd_idx), .pr_rd_val(pr_rd_val)
   );

   initial begin
      clk = 1'b0;
      forever #10 clk = ~clk;
   end

   initial begin
      #(20 * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = 0; wr_spec = 0; wr_fault = 0; wr_idx = 0; wr_data = 0;
      chk_en = 0; chk_idx = 0; cmp_en = 0; cmp_kind = 0; cmp_a = 0; cmp_b = 0;
      cmp_pt = 0; cmp_pf = 0; rot_en = 0; rot_in = 0;
   endtask

   function automatic logic cmp_ref(logic [1:0] k, logic [63:0] a, logic [63:0] b);
      case (k)
         2'd0:    return a == b;
         2'd1:    return $signed(a) < $signed(b);
         2'd2:    return a < b;
         default: return a != b;
      endcase
   endfunction

   task automatic gr_write(logic [6:0] idx, logic [63:0] d, logic spec, logic flt);
      @(negedge clk);
      idle();
      wr_en = 1; wr_idx = idx; wr_data = d; wr_spec = spec; wr_fault = flt;
      @(negedge clk);
      idle();
   endtask

   // one predicate step; the model rotates first, then applies the compare
   task automatic pred_step(logic ce, logic [1:0] k, logic [63:0] a, logic [63:0] b,
                            logic [5:0] pt, logic [5:0] pf, logic re, logic ri);
      logic r;
      @(negedge clk);
      idle();
      cmp_en = ce; cmp_kind = k; cmp_a = a; cmp_b = b; cmp_pt = pt; cmp_pf = pf;
      rot_en = re; rot_in = ri;
      r = cmp_ref(k, a, b);
      if (re) mdl = {mdl[62:16], ri, mdl[15:0]};
      if (ce) begin
         mdl[pf] = ~r;
         mdl[pt] = r;
      end
      mdl[0] = 1'b1;
      @(negedge clk);
      idle();
   endtask

   task automatic check_bank(string req);
      logic [63:0] got;
      for (int i = 0; i < 64; i++) begin
         pr_rd_idx = i[5:0];
         #0.1;
         got[i] = pr_rd_val;
      end
      check(req, got, mdl);
   endtask

   task automatic t_reset();
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      mdl = 64'h1;
      rd_a_idx = 0; rd_b_idx = 127; #1;
      check("R1 rd_a after reset", rd_a_data, 0);
      check("R1 rd_b after reset", rd_b_data, 0);
      check("R1 poison after reset", {rd_a_poison, rd_b_poison}, 0);
      check_bank("R1 predicates after reset");
   endtask

   task automatic t_normal();
      gr_write(7'd5, 64'h0123_4567_89ab_cdef, 0, 0);
      gr_write(7'd127, 64'hffff_0000_ffff_0000, 0, 0);
      rd_a_idx = 5; rd_b_idx = 127; #1;
      check("R2 reg5 data", rd_a_data, 64'h0123_4567_89ab_cdef);
      check("R2 reg127 data", rd_b_data, 64'hffff_0000_ffff_0000);
   endtask

   task automatic t_bypass();
      @(negedge clk);
      wr_en = 1; wr_idx = 9; wr_data = 64'hdead_beef_0000_0009;
      rd_a_idx = 9; rd_b_idx = 9; #1;
      check("R3 fwd port A", rd_a_data, 64'hdead_beef_0000_0009);
      check("R3 fwd port B", rd_b_data, 64'hdead_beef_0000_0009);
      @(negedge clk);
      idle();
      wr_en = 1; wr_idx = 9; wr_spec = 1; wr_fault = 1; wr_data = 64'h1;
      #1;
      check("R3 fwd faulting load data and poison", {rd_a_data, 63'b0, rd_a_poison},
            {64'hdead_beef_0000_0009, 64'h1});
      @(negedge clk);
      idle();
   endtask

   task automatic t_spec_fault();
      gr_write(7'd20, 64'haaaa, 0, 0);
      gr_write(7'd20, 64'hbbbb, 1, 1);
      rd_a_idx = 20; #1;
      check("R4 data kept", rd_a_data, 64'haaaa);
      check("R4 poison set", rd_a_poison, 1);
      chk_en = 1; chk_idx = 20; #1;
      check("R6 trap on poisoned", chk_trap, 1);
      chk_idx = 21; #1;
      check("R6 no trap on clean", chk_trap, 0);
      chk_idx = 20; chk_en = 0; #1;
      check("R6 no trap when disabled", chk_trap, 0);
      gr_write(7'd20, 64'hcccc, 0, 0);
      chk_en = 1; chk_idx = 20; #1;
      check("R2 normal write clears poison", chk_trap, 0);
      chk_en = 0;
   endtask

   task automatic t_spec_clean();
      gr_write(7'd30, 64'h1111, 1, 1);
      gr_write(7'd30, 64'h3030, 1, 0);
      rd_b_idx = 30; #1;
      check("R5 clean load data", rd_b_data, 64'h3030);
      check("R5 clean load poison", rd_b_poison, 0);
   endtask

   task automatic t_same_cycle_chk();
      @(negedge clk);
      idle();
      wr_en = 1; wr_idx = 40; wr_spec = 1; wr_fault = 1;
      chk_en = 1; chk_idx = 40; #1;
      check("R6 trap with same-cycle fault", chk_trap, 1);
      @(negedge clk);
      idle();
      wr_en = 1; wr_idx = 40; wr_data = 64'h4;
      chk_en = 1; chk_idx = 40; #1;
      check("R6 no trap with same-cycle clear", chk_trap, 0);
      @(negedge clk);
      idle();
   endtask

   task automatic t_compare();
      pred_step(1, 2'd1, 64'hffff_ffff_ffff_ffff, 64'h1, 6'd1, 6'd2, 0, 0);
      check_bank("R7 signed less-than");
      pred_step(1, 2'd2, 64'hffff_ffff_ffff_ffff, 64'h1, 6'd1, 6'd2, 0, 0);
      check_bank("R7 unsigned less-than");
      pred_step(1, 2'd0, 64'h77, 64'h77, 6'd5, 6'd6, 0, 0);
      check_bank("R7 equal");
      pred_step(1, 2'd3, 64'h77, 64'h77, 6'd7, 6'd8, 0, 0);
      check_bank("R7 not equal");
   endtask

   task automatic t_pred0();
      pred_step(1, 2'd0, 64'h1, 64'h2, 6'd0, 6'd3, 0, 0);
      pr_rd_idx = 0; #1;
      check("R8 p0 after false write", pr_rd_val, 1);
      check_bank("R8 bank after p0 target");
   endtask

   task automatic t_rotate();
      pred_step(1, 2'd0, 64'h0, 64'h0, 6'd16, 6'd4, 0, 0);
      pred_step(1, 2'd0, 64'h0, 64'h0, 6'd63, 6'd9, 0, 0);
      pred_step(0, 2'd0, 64'h0, 64'h0, 6'd0, 6'd0, 1, 1);
      check_bank("R9 rotate in 1");
      pred_step(0, 2'd0, 64'h0, 64'h0, 6'd0, 6'd0, 1, 0);
      check_bank("R9 rotate in 0");
      for (int i = 0; i < 3; i++) pred_step(0, 2'd0, 64'h0, 64'h0, 6'd0, 6'd0, 1, 1);
      check_bank("R9 rotate burst");
   endtask

   task automatic t_rot_cmp();
      pred_step(1, 2'd1, 64'h1, 64'h2, 6'd17, 6'd20, 1, 0);
      check_bank("R10 compare with rotate");
      pred_step(1, 2'd0, 64'h1, 64'h2, 6'd16, 6'd40, 1, 1);
      check_bank("R10 compare on insert slot");
   endtask

   task automatic t_same_target();
      pred_step(1, 2'd1, 64'h1, 64'h2, 6'd40, 6'd40, 0, 0);
      pr_rd_idx = 40; #1;
      check("R11 equal targets true", pr_rd_val, 1);
      pred_step(1, 2'd1, 64'h3, 64'h2, 6'd40, 6'd40, 0, 0);
      pr_rd_idx = 40; #1;
      check("R11 equal targets false", pr_rd_val, 0);
   endtask

   initial begin
      idle();
      rst_n = 0; rd_a_idx = 0; rd_b_idx = 0; pr_rd_idx = 0; mdl = 64'h1;
      t_reset();
      t_normal();
      t_bypass();
      t_spec_fault();
      t_spec_clean();
      t_same_cycle_chk();
      t_compare();
      t_pred0();
      t_rotate();
      t_rot_cmp();
      t_same_target();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule